// File: doc/BRIEF.md
# Timed-Edge Encoded Logic Gate

This block is a Boolean gate whose inputs and output are not plain bits but timed-edge encodings. Within one period of a fixed-frequency reference clock, each encoded signal carries the level it holds at the start of the period. It also carries a short, ascending list of transition offsets, each a W-bit fraction of the period measured from the reference edge. The encoding lets a cycle-based design model sub-cycle edge timing. A larger W gives a finer resolution.

The gate conditions each input and discards unused slots. It merges the transitions of all inputs into one list ordered by time, with a fixed precedence when offsets tie. It then re-evaluates the selected function (AND, OR or XOR, chosen by parameter) after every input transition and emits an output transition wherever the result flips. An optional filter removes pulses narrower than a minimum width, which includes the zero-width pulses that same-offset edges produce.

The whole path is combinational, so the output encoding belongs to the same reference cycle as the inputs. A sequential model built from such cells uses this gate as its logic stage.

Top module: `tedge_gate`

## Requirements
- R1: Each input is encoded as {start level, count, K offsets}. Input i uses bit i of `in_lvl`, bits [i*CW +: CW] of `in_cnt` and offset slot s at bits [(i*K+s)*W +: W] of `in_off`. Only slots s < count are transitions, slots at or beyond the count are ignored, and a count above K is treated as K.
- R2: The output start level `out_lvl` equals the gate function applied to the input start levels.
- R3: Transitions from all inputs are processed in ascending offset order. On equal offsets, the transition of the lower-numbered input is processed first.
- R4: After each processed input transition the function is re-evaluated. An output transition at that same offset is emitted only when the function value changes.
- R5: With filtering disabled, the output holds every raw transition, up to N*K per cycle. Output slot p sits at bits [p*W +: W] of `out_off`, and `out_cnt` gives the number of valid slots.
- R6: With filtering enabled, a transition whose offset lies less than MIN_W after the last kept transition cancels that kept transition, so both vanish. This covers zero-width pulses. A gap of exactly MIN_W is kept.
- R7: The level at the end of the cycle, `out_lvl` XOR the parity of `out_cnt`, equals the function of the inputs' end-of-cycle levels. This holds for any offset resolution, so the cell matches a plain gate sampled once per reference cycle.
- R8: The output encoding follows an input change within the same reference cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_lvl | input | N | Start level of each input |
| in_cnt | input | N*CW | Transition count of each input |
| in_off | input | N*K*W | Offset slots of each input, ascending within the count |
| out_lvl | output | 1 | Start level of the output |
| out_cnt | output | OCW | Number of valid output transitions |
| out_off | output | N*K*W | Output offset slots, ascending; unused slots are zero |

## Verification
Ordering and filtering collide when two inputs switch at the same offset in opposite directions. The tie order then decides whether the gate produces a zero-width output pulse, and the filter decides whether that pulse survives. The bench provokes this with coincident edges on both inputs. It judges the tie order on an unfiltered AND instance, where the wrong order would create a spurious pulse. The same stimulus on the filtered instance must give an empty transition list and an unchanged level.

// File: rtl/tedge_pkg.sv
package tedge_pkg;

  typedef enum logic [1:0] {
    GATE_AND = 2'd0,
    GATE_OR  = 2'd1,
    GATE_XOR = 2'd2
  } gate_fn_e;

  // Boolean reduction over the first n bits of v
  function automatic logic gate_eval(gate_fn_e fn, logic [15:0] v, int n);
    logic r;
    r = (fn == GATE_AND);
    for (int i = 0; i < 16; i++) begin
      if (i < n) begin
        case (fn)
          GATE_AND: r = r & v[i];
          GATE_OR:  r = r | v[i];
          default:  r = r ^ v[i];
        endcase
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/tedge_cond.sv
module tedge_cond #(
  parameter int N  = 2,
  parameter int K  = 4,
  parameter int W  = 4,
  parameter int CW = $clog2(K + 1)
) (
  input  logic [N*CW-1:0]  in_cnt,
  input  logic [N*K*W-1:0] in_off,
  output logic [N*K-1:0]   slot_vld
);

  for (genvar i = 0; i < N; i++) begin : g_in
    logic [CW-1:0] cnt_cl;
    assign cnt_cl = (in_cnt[i*CW +: CW] > CW'(K)) ? CW'(K) : in_cnt[i*CW +: CW];

    for (genvar s = 0; s < K; s++) begin : g_slot
      assign slot_vld[i*K+s] = (CW'(s) < cnt_cl);
    end

    // valid offsets of one input must be non-decreasing
    always_comb begin
      for (int s = 1; s < K; s++) begin
        if (CW'(s) < cnt_cl) begin
          p_in_order_r1: assert (in_off[(i*K+s)*W +: W] >= in_off[(i*K+s-1)*W +: W]);
        end
      end
    end
  end

endmodule

// File: rtl/tedge_sort.sv
module tedge_sort #(
  parameter int N   = 2,
  parameter int K   = 4,
  parameter int W   = 4,
  localparam int M  = N * K,
  localparam int SW = (N > 1) ? $clog2(N) : 1,
  localparam int OCW = $clog2(M + 1)
) (
  input  logic [M-1:0]   slot_vld,
  input  logic [M*W-1:0] slot_off,
  output logic [OCW-1:0] srt_n,
  output logic [M*W-1:0] srt_off,
  output logic [M*SW-1:0] srt_src
);

  int rank_q [M];

  always_comb begin
    srt_off = '0;
    srt_src = '0;
    srt_n   = '0;
    for (int e = 0; e < M; e++) begin
      rank_q[e] = 0;
      if (slot_vld[e]) srt_n = srt_n + OCW'(1);
      // entry b goes ahead of e on a smaller offset or, on a tie, a lower index
      for (int b = 0; b < M; b++) begin
        if (slot_vld[b] && ((slot_off[b*W +: W] < slot_off[e*W +: W]) ||
            ((slot_off[b*W +: W] == slot_off[e*W +: W]) && (b < e))))
          rank_q[e] = rank_q[e] + 1;
      end
    end
    for (int p = 0; p < M; p++) begin
      for (int e = 0; e < M; e++) begin
        if (slot_vld[e] && (rank_q[e] == p)) begin
          srt_off[p*W +: W]   = slot_off[e*W +: W];
          srt_src[p*SW +: SW] = SW'(e / K);
        end
      end
    end
    for (int p = 1; p < M; p++) begin
      if (OCW'(p) < srt_n) begin
        p_sort_order_r3: assert (srt_off[p*W +: W] >= srt_off[(p-1)*W +: W]);
      end
    end
  end

endmodule

// File: rtl/tedge_eval.sv
module tedge_eval
  import tedge_pkg::*;
#(
  parameter int N   = 2,
  parameter int K   = 4,
  parameter int W   = 4,
  parameter gate_fn_e FN = GATE_AND,
  localparam int M  = N * K,
  localparam int SW = (N > 1) ? $clog2(N) : 1,
  localparam int OCW = $clog2(M + 1)
) (
  input  logic [N-1:0]    in_lvl,
  input  logic [OCW-1:0]  srt_n,
  input  logic [M*W-1:0]  srt_off,
  input  logic [M*SW-1:0] srt_src,
  output logic            raw_lvl,
  output logic [OCW-1:0]  raw_n,
  output logic [M*W-1:0]  raw_off
);

  logic [N-1:0] cur;
  logic         prev, nxt;

  always_comb begin
    cur     = in_lvl;
    raw_lvl = gate_eval(FN, 16'(in_lvl), N);
    prev    = raw_lvl;
    nxt     = raw_lvl;
    raw_n   = '0;
    raw_off = '0;
    for (int p = 0; p < M; p++) begin
      if (OCW'(p) < srt_n) begin
        cur[int'(srt_src[p*SW +: SW])] = ~cur[int'(srt_src[p*SW +: SW])];
        nxt = gate_eval(FN, 16'(cur), N);
        if (nxt != prev) begin
          raw_off[int'(raw_n)*W +: W] = srt_off[p*W +: W];
          raw_n = raw_n + OCW'(1);
        end
        prev = nxt;
      end
    end
    // one output edge at most per input edge
    p_raw_bound_r5: assert (raw_n <= srt_n);
  end

endmodule

// File: rtl/tedge_filt.sv
module tedge_filt #(
  parameter int M       = 8,
  parameter int W       = 4,
  parameter bit FILT_EN = 1'b1,
  parameter int MIN_W   = 2,
  localparam int OCW    = $clog2(M + 1)
) (
  input  logic [OCW-1:0] raw_n,
  input  logic [M*W-1:0] raw_off,
  output logic [OCW-1:0] out_n,
  output logic [M*W-1:0] out_off
);

  if (FILT_EN) begin : g_filt
    logic [W-1:0] stk [M];
    int           top;

    always_comb begin
      top = 0;
      for (int p = 0; p < M; p++) stk[p] = '0;
      for (int p = 0; p < M; p++) begin
        if (OCW'(p) < raw_n) begin
          if ((top > 0) && ((int'(raw_off[p*W +: W]) - int'(stk[top-1])) < MIN_W)) begin
            top = top - 1;
          end else begin
            stk[top] = raw_off[p*W +: W];
            top = top + 1;
          end
        end
      end
      out_n   = OCW'(top);
      out_off = '0;
      for (int p = 0; p < M; p++) begin
        if (p < top) out_off[p*W +: W] = stk[p];
      end
      // kept neighbours are never closer than the minimum width
      for (int p = 1; p < M; p++) begin
        if (p < top) begin
          p_min_gap_r6: assert ((int'(stk[p]) - int'(stk[p-1])) >= MIN_W);
        end
      end
    end
  end else begin : g_pass
    assign out_n   = raw_n;
    assign out_off = raw_off;
  end

endmodule

// File: rtl/tedge_gate.sv
module tedge_gate
  import tedge_pkg::*;
#(
  parameter int N         = 2,
  parameter int K         = 4,
  parameter int W         = 4,
  parameter gate_fn_e FN  = GATE_AND,
  parameter bit FILT_EN   = 1'b1,
  parameter int MIN_W     = 2,
  localparam int CW       = $clog2(K + 1),
  localparam int M        = N * K,
  localparam int SW       = (N > 1) ? $clog2(N) : 1,
  localparam int OCW      = $clog2(M + 1)
) (
  input  logic [N-1:0]    in_lvl,
  input  logic [N*CW-1:0] in_cnt,
  input  logic [M*W-1:0]  in_off,
  output logic            out_lvl,
  output logic [OCW-1:0]  out_cnt,
  output logic [M*W-1:0]  out_off
);

  logic [M-1:0]    slot_vld;
  logic [OCW-1:0]  srt_n, raw_n;
  logic [M*W-1:0]  srt_off, raw_off;
  logic [M*SW-1:0] srt_src;

  tedge_cond #(.N(N), .K(K), .W(W), .CW(CW)) u_cond (
    .in_cnt  (in_cnt),
    .in_off  (in_off),
    .slot_vld(slot_vld)
  );

  tedge_sort #(.N(N), .K(K), .W(W)) u_sort (
    .slot_vld(slot_vld),
    .slot_off(in_off),
    .srt_n   (srt_n),
    .srt_off (srt_off),
    .srt_src (srt_src)
  );

  tedge_eval #(.N(N), .K(K), .W(W), .FN(FN)) u_eval (
    .in_lvl (in_lvl),
    .srt_n  (srt_n),
    .srt_off(srt_off),
    .srt_src(srt_src),
    .raw_lvl(out_lvl),
    .raw_n  (raw_n),
    .raw_off(raw_off)
  );

  tedge_filt #(.M(M), .W(W), .FILT_EN(FILT_EN), .MIN_W(MIN_W)) u_filt (
    .raw_n  (raw_n),
    .raw_off(raw_off),
    .out_n  (out_cnt),
    .out_off(out_off)
  );

endmodule

// File: tb/tedge_gate_test.sv
module tedge_gate_test;
  import tedge_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  in_lvl = '0;
  logic [5:0]  in_cnt = '0;
  logic [31:0] in_off = '0;

  logic        a_lvl, x_lvl, r_lvl, o_lvl;
  logic [3:0]  a_cnt, x_cnt, r_cnt, o_cnt;
  logic [31:0] a_off, x_off, r_off, o_off;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // filtered AND
  tedge_gate #(.FN(GATE_AND), .FILT_EN(1'b1), .MIN_W(2)) uut (
    .in_lvl(in_lvl), .in_cnt(in_cnt), .in_off(in_off),
    .out_lvl(a_lvl), .out_cnt(a_cnt), .out_off(a_off));
  // raw XOR
  tedge_gate #(.FN(GATE_XOR), .FILT_EN(1'b0)) u_xraw (
    .in_lvl(in_lvl), .in_cnt(in_cnt), .in_off(in_off),
    .out_lvl(x_lvl), .out_cnt(x_cnt), .out_off(x_off));
  // raw AND
  tedge_gate #(.FN(GATE_AND), .FILT_EN(1'b0)) u_araw (
    .in_lvl(in_lvl), .in_cnt(in_cnt), .in_off(in_off),
    .out_lvl(r_lvl), .out_cnt(r_cnt), .out_off(r_off));
  // raw OR
  tedge_gate #(.FN(GATE_OR), .FILT_EN(1'b0)) u_or (
    .in_lvl(in_lvl), .in_cnt(in_cnt), .in_off(in_off),
    .out_lvl(o_lvl), .out_cnt(o_cnt), .out_off(o_off));

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // drive at the falling edge, sample a quarter period later
  task automatic drive(logic al, logic bl, logic [2:0] ac, logic [2:0] bc,
                       logic [15:0] ao, logic [15:0] bo);
    @(negedge clk);
    in_lvl = {bl, al};
    in_cnt = {bc, ac};
    in_off = {bo, ao};
    #(CLK_PERIOD/4);
  endtask

  task automatic t_idle();
    chk("R2 idle lvl", 32'(a_lvl), 32'd0);
    chk("R2 idle cnt", 32'(a_cnt), 32'd0);
    drive(1, 1, 0, 0, 16'h0, 16'h0);
    chk("R2 start AND", 32'(a_lvl), 32'd1);
    chk("R2 start XOR", 32'(x_lvl), 32'd0);
  endtask

  task automatic t_basic();
    // R8: result observed within the same cycle as the drive
    drive(0, 1, 2, 1, 16'h00A3, 16'h0006);
    chk("R4 cnt", 32'(a_cnt), 32'd2);
    chk("R4 off", a_off, 32'h0000_0063);
    chk("R8 lvl", 32'(a_lvl), 32'd0);
    drive(0, 0, 1, 1, 16'h0002, 16'h0005);
    chk("R4 OR cnt", 32'(o_cnt), 32'd1);
    chk("R4 OR off", o_off, 32'h0000_0002);
  endtask

  task automatic t_coincident();
    drive(0, 1, 1, 1, 16'h0005, 16'h0005);
    chk("R6 zero-width cnt", 32'(a_cnt), 32'd0);
    chk("R3 XOR lvl", 32'(x_lvl), 32'd1);
    chk("R3 XOR cnt", 32'(x_cnt), 32'd2);
    chk("R3 XOR off", x_off, 32'h0000_0055);
    drive(1, 0, 1, 1, 16'h0007, 16'h0007);
    chk("R3 tie order AND cnt", 32'(r_cnt), 32'd0);
    chk("R3 tie order AND lvl", 32'(r_lvl), 32'd0);
  endtask

  task automatic t_narrow();
    drive(0, 1, 2, 0, 16'h0054, 16'h0);
    chk("R6 narrow cnt", 32'(a_cnt), 32'd0);
    chk("R6 narrow raw cnt", 32'(r_cnt), 32'd2);
    chk("R6 narrow raw off", r_off, 32'h0000_0054);
    drive(0, 1, 2, 0, 16'h0064, 16'h0);
    chk("R6 edge-width cnt", 32'(a_cnt), 32'd2);
    chk("R6 edge-width off", a_off, 32'h0000_0064);
  endtask

  task automatic t_slots();
    drive(0, 1, 7, 0, 16'hC841, 16'h0);
    chk("R1 clamp cnt", 32'(a_cnt), 32'd4);
    chk("R1 clamp off", a_off, 32'h0000_C841);
    drive(0, 1, 2, 0, 16'h2173, 16'hFFFF);
    chk("R1 unused cnt", 32'(a_cnt), 32'd2);
    chk("R1 unused off", a_off, 32'h0000_0073);
  endtask

  task automatic t_full();
    drive(0, 0, 4, 4, 16'h6420, 16'h7531);
    chk("R5 full cnt", 32'(x_cnt), 32'd8);
    chk("R5 full off", x_off, 32'h7654_3210);
    chk("R5 full lvl", 32'(x_lvl), 32'd0);
  endtask

  task automatic t_endlevel();
    for (int al = 0; al < 2; al++)
      for (int bl = 0; bl < 2; bl++)
        for (int ac = 0; ac < 5; ac++)
          for (int bc = 0; bc < 5; bc++) begin
            logic ae, be;
            drive(al[0], bl[0], 3'(ac), 3'(bc), 16'hC941, 16'hD942);
            ae = al[0] ^ ac[0];
            be = bl[0] ^ bc[0];
            chk("R7 AND end", 32'(a_lvl ^ a_cnt[0]), 32'(ae & be));
            chk("R7 XOR end", 32'(x_lvl ^ x_cnt[0]), 32'(ae ^ be));
          end
  endtask

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    t_idle();
    t_basic();
    t_coincident();
    t_narrow();
    t_slots();
    t_full();
    t_endlevel();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule